// File: doc/BRIEF.md
# Write-Coalescing Command Buffer Builder

This block turns a stream of register write requests, each an offset and a 32-bit value, into a packed list of 64-bit instructions. It writes them one dword per cycle into an external dword-addressed command memory. A register write engine elsewhere later executes that list. Each instruction takes two dwords and starts at an even dword index.

A write to a new register becomes a single-write instruction. A repeated write to the register just written is merged in place. The earlier single write is rewritten as an indexed write with a count dword, and the new value is appended after it. Further repeats to that register keep appending values and bumping the count. If the payload has an odd length, a zero dword pads the last instruction.

A finish strobe zero-fills the memory up to the next 16-dword (64-byte) boundary. The tail output then gives the byte length of the list. A clear strobe restarts the list from index 0.

The sequencer is a single state machine. Its states are:

| State | Action |
|-------|--------|
| `ST_IDLE` | Ready for requests and strobes. |
| `ST_S_VAL`, `ST_S_HDR` | Write the value, then the header, of a single write. |
| `ST_C_CNT`, `ST_C_HDR`, `ST_C_OLD`, `ST_C_NEW` | Convert a single write to an indexed write: write the count, the indexed header, the old value, then the new value. |
| `ST_A_VAL`, `ST_A_CNT`, `ST_A_PAD` | Append a value to an indexed write, rewrite its count, and write the zero pad if needed. |
| `ST_F_PAD`, `ST_F_DONE` | Zero-fill up to the boundary, then signal completion. |

The transitions are:

- **From `ST_IDLE`:**
  - `clear_i` keeps the machine in `ST_IDLE`.
  - `finish_i` goes to `ST_F_DONE` if the free index is already on a boundary, otherwise to `ST_F_PAD`.
  - An accepted request that has room goes to `ST_A_VAL` (hit on an indexed write), `ST_C_CNT` (hit on a single write) or `ST_S_VAL` (new register).
  - A request without room stays in `ST_IDLE`.
- **Fixed chains:**
  - `ST_S_VAL` → `ST_S_HDR` → `ST_IDLE`
  - `ST_C_CNT` → `ST_C_HDR` → `ST_C_OLD` → `ST_C_NEW` → `ST_IDLE`
  - `ST_A_VAL` → `ST_A_CNT`
- **Conditional exits:**
  - `ST_A_CNT` goes to `ST_A_PAD` when the free index is odd, otherwise to `ST_IDLE`; `ST_A_PAD` → `ST_IDLE`.
  - `ST_F_PAD` loops until the last dword before the boundary is written, then goes to `ST_F_DONE`; `ST_F_DONE` → `ST_IDLE`.
- **From any state:** `clear_i` returns to `ST_IDLE`.

Top module: `wcb_builder`

## Requirements
- R1: A write to a register that does not match the tracked previous instruction becomes a single write. The value goes at dword index k and the header at k+1. The header holds 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0.
- R2: Before a new instruction is placed, an odd free index is rounded up to the next even index, so k is always even.
- R3: A request arriving when free index + 2 exceeds the buffer size in dwords is accepted but writes nothing. It also sets `overflow_o`, which stays high until clear or reset.
- R4: A write to the same offset as a tracked single write at index k rewrites it as an indexed write:
  - dword k holds the count 2;
  - dword k+1 holds 0x09 in bits 31:24, zero in bits 23:20 and the offset in bits 19:0;
  - dword k+2 holds the old value;
  - dword k+3 holds the new value;
  - the free index becomes k+4.
- R5: A write to the same offset as a tracked indexed write stores the value at the free index, advances the free index by one, and rewrites the count dword at k with the new count.
- R6: After an append, if the free index is odd, the dword at the free index is written with zero.
- R7: On finish, zeros are written from the free index up to the next multiple of 16 dwords, and the free index moves there. `done_o` then pulses for one cycle. If the free index is already a multiple of 16, nothing is written.
- R8: The buffer size in dwords is 2 × `max_cmds_i` rounded up to a multiple of 16.
- R9: Reset and `clear_i` set the free index and instruction start to 0, forget the previous instruction, and clear `overflow_o`. `tail_o` always equals the free index × 4.
- R10: `req_ready_o` is high only in the idle state with no finish or clear strobe. It is low during every multi-cycle write sequence.
- R11: After a finish, the next write never merges with an instruction placed before the finish.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| max_cmds_i | input | CMD_W | Number of commands the buffer must hold |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Write request accepted when high with valid |
| req_offset_i | input | 20 | Register offset of the request |
| req_value_i | input | 32 | Value of the request |
| finish_i | input | 1 | Pad to the boundary and publish the tail |
| clear_i | input | 1 | Restart the list at index 0 |
| mem_we_o | output | 1 | Command memory write enable |
| mem_addr_o | output | CMD_W+2 | Dword index written |
| mem_wdata_o | output | 32 | Dword written |
| overflow_o | output | 1 | Sticky: a request was dropped for lack of room |
| tail_o | output | CMD_W+4 | Byte offset of the free position |
| done_o | output | 1 | One-cycle pulse when a finish completes |

## Verification
The hardest situation to reach is a same-offset append that lands on an odd free index right after an earlier instruction left an even one. That case needs a single write, a conversion and then a third write to the same register, in that order. The stimulus table therefore runs two separate three-write streaks, with unrelated singles between them. A new register after the second streak then forces the round-up from an odd index. The exact-fit and one-past-fit boundaries are driven with a buffer size that rounding enlarges (9 commands become 32 dwords), so the overflow check is shown to use the rounded size.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int OFF_W   = 20;
    localparam int DW      = 32;
    localparam int LINE_DW = 16;

    localparam logic [7:0] OP_SINGLE  = 8'h01;
    localparam logic [7:0] OP_INDEXED = 8'h09;
    localparam logic [3:0] BE_ALL     = 4'hF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_VAL,
        ST_S_HDR,
        ST_C_CNT,
        ST_C_HDR,
        ST_C_OLD,
        ST_C_NEW,
        ST_A_VAL,
        ST_A_CNT,
        ST_A_PAD,
        ST_F_PAD,
        ST_F_DONE
    } wcb_state_e;

    function automatic logic [DW-1:0] single_hdr(input logic [OFF_W-1:0] off);
        return {OP_SINGLE, BE_ALL, off};
    endfunction

    function automatic logic [DW-1:0] indexed_hdr(input logic [OFF_W-1:0] off);
        return {OP_INDEXED, 4'h0, off};
    endfunction

endpackage

// File: rtl/wcb_sizer.sv
module wcb_sizer #(
    parameter int CMD_W   = 10,
    parameter int LINE_DW = 16,
    parameter int POS_W   = CMD_W + 2
) (
    input  logic [CMD_W-1:0] max_cmds_i,
    output logic [POS_W-1:0] size_dw_o
);

    localparam int LINE_SH = $clog2(LINE_DW);

    logic [POS_W-1:0] raw_dw;

    // two dwords per command, then round up to a whole line
    assign raw_dw    = POS_W'({max_cmds_i, 1'b0}) + POS_W'(LINE_DW - 1);
    assign size_dw_o = {raw_dw[POS_W-1:LINE_SH], LINE_SH'(0)};

endmodule

// File: rtl/wcb_prev_track.sv
module wcb_prev_track #(
    parameter int POS_W = 12,
    parameter int OFF_W = 20,
    parameter int DW    = 32,
    parameter int CNT_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             conv_i,
    input  logic             bump_i,
    input  logic [POS_W-1:0] start_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [DW-1:0]    val_i,
    output logic             vld_o,
    output logic             idx_o,
    output logic [POS_W-1:0] start_o,
    output logic [OFF_W-1:0] off_o,
    output logic [DW-1:0]    val_o,
    output logic [CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o   <= 1'b0;
            idx_o   <= 1'b0;
            start_o <= '0;
            off_o   <= '0;
            val_o   <= '0;
            cnt_o   <= '0;
        end else if (clr_i) begin
            vld_o   <= 1'b0;
            idx_o   <= 1'b0;
            start_o <= '0;
            cnt_o   <= '0;
        end else if (load_i) begin
            vld_o   <= 1'b1;
            idx_o   <= 1'b0;
            start_o <= start_i;
            off_o   <= off_i;
            val_o   <= val_i;
            cnt_o   <= CNT_W'(1);
        end else if (conv_i) begin
            idx_o   <= 1'b1;
            cnt_o   <= CNT_W'(2);
        end else if (bump_i) begin
            cnt_o   <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/wcb_builder.sv
module wcb_builder
    import wcb_pkg::*;
#(
    parameter int CMD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CMD_W-1:0]   max_cmds_i,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [19:0]        req_offset_i,
    input  logic [31:0]        req_value_i,
    input  logic               finish_i,
    input  logic               clear_i,
    output logic               mem_we_o,
    output logic [CMD_W+1:0]   mem_addr_o,
    output logic [31:0]        mem_wdata_o,
    output logic               overflow_o,
    output logic [CMD_W+3:0]   tail_o,
    output logic               done_o
);

    localparam int POS_W   = CMD_W + 2;
    localparam int CNT_W   = POS_W + 1;
    localparam int LINE_SH = $clog2(LINE_DW);

    wcb_state_e          state_q, state_d;
    logic [POS_W-1:0]    free_q;
    logic [POS_W-1:0]    size_dw;
    logic [OFF_W-1:0]    req_off_q;
    logic [DW-1:0]       req_val_q;
    logic                ovf_q;

    logic                prv_vld, prv_idx;
    logic [POS_W-1:0]    prv_start;
    logic [OFF_W-1:0]    prv_off;
    logic [DW-1:0]       prv_val;
    logic [CNT_W-1:0]    prv_cnt;

    logic                in_idle, accept, no_room, hit_any, hit_single, hit_idx;
    logic                line_aligned, fin_go;
    logic [POS_W-1:0]    even_pos;

    wcb_sizer #(.CMD_W(CMD_W), .LINE_DW(LINE_DW), .POS_W(POS_W)) u_sizer (
        .max_cmds_i (max_cmds_i),
        .size_dw_o  (size_dw)
    );

    assign in_idle      = (state_q == ST_IDLE);
    assign fin_go       = in_idle && finish_i && !clear_i;
    assign accept       = in_idle && req_valid_i && !finish_i && !clear_i;
    assign no_room      = (CNT_W'(free_q) + CNT_W'(2)) > CNT_W'(size_dw);
    assign hit_any      = prv_vld && (prv_off == req_offset_i);
    assign hit_single   = hit_any && !prv_idx;
    assign hit_idx      = hit_any && prv_idx;
    assign even_pos     = free_q + POS_W'(free_q[0]);
    assign line_aligned = (free_q[LINE_SH-1:0] == '0);

    wcb_prev_track #(.POS_W(POS_W), .OFF_W(OFF_W), .DW(DW), .CNT_W(CNT_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clear_i || fin_go),
        .load_i  (accept && !no_room && !hit_any),
        .conv_i  (accept && !no_room && hit_single),
        .bump_i  (accept && !no_room && hit_idx),
        .start_i (even_pos),
        .off_i   (req_offset_i),
        .val_i   (req_value_i),
        .vld_o   (prv_vld),
        .idx_o   (prv_idx),
        .start_o (prv_start),
        .off_o   (prv_off),
        .val_o   (prv_val),
        .cnt_o   (prv_cnt)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fin_go)
                    state_d = line_aligned ? ST_F_DONE : ST_F_PAD;
                else if (accept && !no_room)
                    state_d = hit_idx ? ST_A_VAL : (hit_single ? ST_C_CNT : ST_S_VAL);
            end
            ST_S_VAL:  state_d = ST_S_HDR;
            ST_S_HDR:  state_d = ST_IDLE;
            ST_C_CNT:  state_d = ST_C_HDR;
            ST_C_HDR:  state_d = ST_C_OLD;
            ST_C_OLD:  state_d = ST_C_NEW;
            ST_C_NEW:  state_d = ST_IDLE;
            ST_A_VAL:  state_d = ST_A_CNT;
            ST_A_CNT:  state_d = free_q[0] ? ST_A_PAD : ST_IDLE;
            ST_A_PAD:  state_d = ST_IDLE;
            ST_F_PAD:  state_d = (free_q[LINE_SH-1:0] == '1) ? ST_F_DONE : ST_F_PAD;
            ST_F_DONE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (clear_i)
            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // free position, latched request and sticky overflow
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q    <= '0;
            req_off_q <= '0;
            req_val_q <= '0;
            ovf_q     <= 1'b0;
        end else if (clear_i) begin
            free_q    <= '0;
            ovf_q     <= 1'b0;
        end else if (accept) begin
            if (no_room) begin
                ovf_q <= 1'b1;
            end else begin
                req_off_q <= req_offset_i;
                req_val_q <= req_value_i;
                if (!hit_any)
                    free_q <= even_pos;
            end
        end else if (state_q inside {ST_S_VAL, ST_S_HDR, ST_C_OLD, ST_C_NEW,
                                     ST_A_VAL, ST_F_PAD}) begin
            free_q <= free_q + POS_W'(1);
        end
    end

    // outputs
    always_comb begin
        mem_we_o    = 1'b0;
        mem_addr_o  = free_q;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_S_VAL: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = req_val_q;
            end
            ST_S_HDR: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = single_hdr(req_off_q);
            end
            ST_C_CNT, ST_A_CNT: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = prv_start;
                mem_wdata_o = DW'(prv_cnt);
            end
            ST_C_HDR: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = prv_start + POS_W'(1);
                mem_wdata_o = indexed_hdr(req_off_q);
            end
            ST_C_OLD: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = prv_val;
            end
            ST_C_NEW, ST_A_VAL: begin
                mem_we_o    = 1'b1;
                mem_wdata_o = req_val_q;
            end
            ST_A_PAD, ST_F_PAD: begin
                mem_we_o    = 1'b1;
            end
            default: ;
        endcase
        req_ready_o = in_idle && !finish_i && !clear_i;
        done_o      = (state_q == ST_F_DONE);
        overflow_o  = ovf_q;
        tail_o      = {free_q, 2'b00};
    end

endmodule

// File: rtl/wcb_builder_chk.sv
module wcb_builder_chk #(
    parameter int CMD_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CMD_W-1:0] max_cmds_i,
    input logic             req_ready_o,
    input logic             clear_i,
    input logic             mem_we_o,
    input logic [CMD_W+1:0] mem_addr_o,
    input logic             overflow_o,
    input logic [CMD_W+3:0] tail_o,
    input logic             done_o
);

    localparam int POS_W = CMD_W + 2;

    logic [POS_W:0] lim_dw;
    assign lim_dw = ((POS_W+1)'({max_cmds_i, 1'b0}) + (POS_W+1)'(15)) & ~(POS_W+1)'(15);

    // R10: nothing is written while the request port is open
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !mem_we_o);

    // R3: no write lands outside the sized buffer
    p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !clear_i) |-> ((POS_W+1)'(mem_addr_o) < lim_dw));

    // R3: overflow is sticky until clear
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow_o && !clear_i) |=> overflow_o);

    // R7: the tail published at done sits on a 64-byte boundary
    p_done_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (tail_o[5:0] == 6'd0));

    // R7: done lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: tail never moves backwards except through clear
    p_tail_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (tail_o >= $past(tail_o)));

    // R9: clear empties the buffer and drops overflow
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (tail_o == '0 && !overflow_o));

endmodule

bind wcb_builder wcb_builder_chk #(.CMD_W(CMD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .max_cmds_i  (max_cmds_i),
    .req_ready_o (req_ready_o),
    .clear_i     (clear_i),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .overflow_o  (overflow_o),
    .tail_o      (tail_o),
    .done_o      (done_o)
);

// File: tb/sim_wcb_builder.sv
`timescale 1ns/1ps
module sim_wcb_builder;

    localparam int CMD_W = 10;
    localparam int POS_W = CMD_W + 2;
    localparam logic [31:0] FILL = 32'hDEADBEEF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CMD_W-1:0] max_cmds = 10'd20;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [19:0]      req_off = '0;
    logic [31:0]      req_val = '0;
    logic             finish = 1'b0;
    logic             clear = 1'b0;
    logic             mem_we;
    logic [POS_W-1:0] mem_addr;
    logic [31:0]      mem_wdata;
    logic             ovf;
    logic [POS_W+1:0] tail;
    logic             done;

    int n_chk  = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    logic [31:0] mem [64];

    always #5 clk = ~clk;

    wcb_builder #(.CMD_W(CMD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .max_cmds_i(max_cmds),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_offset_i(req_off), .req_value_i(req_val),
        .finish_i(finish), .clear_i(clear),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .overflow_o(ovf), .tail_o(tail), .done_o(done)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[5:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // offset, value, expected tail, probe index, probe value
    localparam int NV = 10;
    localparam logic [105:0] VEC [NV] = '{
        {20'h00100, 32'h00000011, 16'd8,  6'd1,  32'h01F00100},
        {20'h00100, 32'h00000022, 16'd16, 6'd1,  32'h09000100},
        {20'h00100, 32'h00000033, 16'd20, 6'd5,  32'h00000000},
        {20'h00100, 32'h00000044, 16'd24, 6'd0,  32'h00000004},
        {20'h00200, 32'h00000055, 16'd32, 6'd7,  32'h01F00200},
        {20'h00100, 32'h00000066, 16'd40, 6'd9,  32'h01F00100},
        {20'h00300, 32'h00000077, 16'd48, 6'd11, 32'h01F00300},
        {20'h00300, 32'h00000088, 16'd56, 6'd10, 32'h00000002},
        {20'h00300, 32'h00000099, 16'd60, 6'd15, 32'h00000000},
        {20'h00400, 32'h000000AA, 16'd72, 6'd16, 32'h000000AA}
    };

    localparam logic [31:0] IMG [18] = '{
        32'h00000004, 32'h09000100, 32'h00000011, 32'h00000022,
        32'h00000033, 32'h00000044, 32'h00000055, 32'h01F00200,
        32'h00000066, 32'h01F00100, 32'h00000003, 32'h09000300,
        32'h00000077, 32'h00000088, 32'h00000099, 32'h00000000,
        32'h000000AA, 32'h01F00400
    };

    function automatic string step_tag(input int i);
        case (i)
            1, 7:    return "R4";
            2, 8:    return "R6";
            3:       return "R5";
            9:       return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < 64; i++) mem[i] = FILL;
    endtask

    task automatic send(input logic [19:0] off, input logic [31:0] val, output logic busy);
        @(negedge clk);
        req_valid = 1'b1;
        req_off   = off;
        req_val   = val;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = !req_ready;
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_finish(output logic saw_done);
        saw_done = 1'b0;
        @(negedge clk);
        finish = 1'b1;
        @(posedge clk);
        @(negedge clk);
        finish = 1'b0;
        for (int k = 0; k < 64; k++) begin
            if (done) saw_done = 1'b1;
            if (req_ready && saw_done) break;
            @(negedge clk);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic busy;
        logic got;
        int   w0;
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 / R10: reset state
        check("R10 ready after reset", 32'(req_ready), 32'd1);
        check("R9 tail after reset", 32'(tail), 32'd0);
        check("R9 overflow after reset", 32'(ovf), 32'd0);
        check("R9 no write after reset", 32'(mem_we), 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][105:86], VEC[i][85:54], busy);
            check(step_tag(i), 32'(tail), 32'(VEC[i][53:38]));
            check(step_tag(i), mem[VEC[i][37:32]], VEC[i][31:0]);
            if (i == 1) check("R10 busy during conversion", 32'(busy), 32'd1);
        end
        for (int i = 0; i < 18; i++) check("R5 image", mem[i], IMG[i]);

        // R7: finish from an unaligned position
        do_finish(got);
        check("R7 done pulse", 32'(got), 32'd1);
        check("R7 tail at boundary", 32'(tail), 32'd128);
        check("R7 pad start", mem[18], 32'h0);
        check("R7 pad end", mem[31], 32'h0);
        check("R7 no overshoot", mem[32], FILL);

        // R11: no merge across finish
        send(20'h00400, 32'h000000BB, busy);
        check("R11 tail", 32'(tail), 32'd136);
        check("R11 value", mem[32], 32'h000000BB);
        check("R11 single header", mem[33], 32'h01F00400);

        // R3: small buffer, one command -> 16 dwords
        do_clear();
        check("R9 tail after clear", 32'(tail), 32'd0);
        fill_mem();
        max_cmds = 10'd1;
        for (int i = 0; i < 8; i++) send(20'h00010 + 20'(i), 32'h100 + 32'(i), busy);
        check("R3 exact fit tail", 32'(tail), 32'd64);
        check("R3 no overflow at fit", 32'(ovf), 32'd0);
        send(20'h00020, 32'h0000BAD0, busy);
        check("R3 overflow set", 32'(ovf), 32'd1);
        check("R3 tail unchanged", 32'(tail), 32'd64);
        check("R3 reject no busy", 32'(busy), 32'd0);
        send(20'h00017, 32'h0000BAD1, busy);
        check("R3 merge also rejected", mem[16], FILL);
        check("R3 overflow sticky", 32'(ovf), 32'd1);

        // R8: 9 commands round up to 32 dwords
        do_clear();
        check("R9 overflow cleared", 32'(ovf), 32'd0);
        max_cmds = 10'd9;
        for (int i = 0; i < 16; i++) send(20'h00040 + 20'(i), 32'h200 + 32'(i), busy);
        check("R8 rounded size fits 16", 32'(ovf), 32'd0);
        check("R8 tail", 32'(tail), 32'd128);
        send(20'h00060, 32'h0000BAD2, busy);
        check("R8 overflow past rounded size", 32'(ovf), 32'd1);

        // R9: clear forgets the previous instruction
        do_clear();
        max_cmds = 10'd20;
        fill_mem();
        send(20'h00055, 32'h00000001, busy);
        do_clear();
        send(20'h00055, 32'h00000002, busy);
        check("R9 no merge after clear", mem[1], 32'h01F00055);
        check("R9 value at zero", mem[0], 32'h00000002);

        // R7: finish when already aligned writes nothing
        do_clear();
        w0 = wr_cnt;
        do_finish(got);
        check("R7 aligned done", 32'(got), 32'd1);
        check("R7 aligned no writes", 32'(wr_cnt - w0), 32'd0);
        check("R7 aligned tail", 32'(tail), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule